// File: doc/BRIEF.md
# Reloading Periodic Interrupt Timer

This block is a down-counting periodic timer driven by a 32768 Hz tick-enable pulse. Software writes a period into a load register and then sets an enable bit in a control register. The enable copies the period into the counter, and each tick decrements the counter. When a tick meets the count of 1, the counter reloads from the load register and a periodic event is latched in a raw status bit. A period of 32768/f ticks therefore gives f events per second. The event reaches the interrupt line through a mask, and software clears it by writing 1 to a clear register.

The period stays fixed while the timer runs: the block ignores a write to the load register while enabled. Software starts the timer by setting the enable bit. As an option it can set a self-start bit, and then the next load write made while stopped starts the timer at once. Access goes through a simple single-cycle register port. Writes take effect at the clock edge and read data is combinational.

The controller has three states. IDLE means stopped. RUN means counting. STALL means enabled with a zero period, which never expires. IDLE moves to RUN on a start with a nonzero period (start-run), or to STALL on a start with a zero period (start-stall). RUN moves to IDLE, and STALL moves to IDLE, when software clears the enable bit (stop). RUN stays in RUN on every tick, with either a decrement or an expire-and-reload.

Top module: `pit_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. The registers are the count (offset 0x20), load (0x24), control (0x28), mask (0x10), raw status (0x14) and masked status (0x18).
- R2: Writing control bit 1 (enable) as 1 while stopped copies the load value into the count. The count does not change until a tick arrives.
- R3: While running, each tick decrements the count. A tick that finds the count at 1 instead reloads the count from the load register and sets raw status bit 1, giving a period of exactly N ticks for a load of N, including N = 1.
- R4: A write to the load register while the timer is enabled has no effect. The load value reads back unchanged and the period stays the same.
- R5: A load write while stopped updates the load register without starting the timer, unless control bit 0 (self-start) is 1. In that case the timer starts counting from the written value and control bit 1 reads 1.
- R6: Writing control bit 1 as 0 stops the timer. Later ticks leave the count unchanged and set no status.
- R7: With a load value of 0 and the enable set, the count stays at 0 and raw status bit 1 is never set.
- R8: Raw status bit 1 stays set until a write to the clear register (0x1C) with bit 1 set. Writing 0 there has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R9: The mask register implements only bit 1, and all its other bits read 0. The masked status reads raw AND mask, and `irq` is high exactly when masked status bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32768 Hz count enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Masked periodic interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same clock cycle as the tick that expires the count. The bench first counts the timer down until the count reads 1. It then uses a single task that raises the tick and drives the clear write on the same edge, and it expects the status bit to survive with the count reloaded. The other corner cases are a load of 1, a zero period with the enable set, and a self-started load write. Each is reached by stopping the timer, reprogramming it and restarting it.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DATA_W = 32;
    typedef logic [7:0] addr_t;

    localparam addr_t OFF_MASK = 8'h10;
    localparam addr_t OFF_RAW  = 8'h14;
    localparam addr_t OFF_MIS  = 8'h18;
    localparam addr_t OFF_CLR  = 8'h1C;
    localparam addr_t OFF_CNT  = 8'h20;
    localparam addr_t OFF_LOAD = 8'h24;
    localparam addr_t OFF_CTRL = 8'h28;

    localparam int PER_BIT  = 1;  // periodic event position in status/mask/clear
    localparam int EN_BIT   = 1;  // control: run enable
    localparam int SELF_BIT = 0;  // control: start on load write

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_STALL = 2'd2
    } pit_state_t;
endpackage

// File: rtl/pit_regfile.sv
module pit_regfile
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  addr_t             bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  load_q,
    input  logic              running,
    input  logic              raw_q,
    input  logic              mask_q,
    output logic              wr_load,
    output logic              wr_ctrl,
    output logic              wr_mask,
    output logic              wr_clr,
    output logic              self_q,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_any;

    assign wr_any  = bus_sel && bus_wr;
    assign wr_load = wr_any && (bus_addr == OFF_LOAD);
    assign wr_ctrl = wr_any && (bus_addr == OFF_CTRL);
    assign wr_mask = wr_any && (bus_addr == OFF_MASK);
    assign wr_clr  = wr_any && (bus_addr == OFF_CLR);

    always_ff @(posedge clk) begin
        if (!rst_n)
            self_q <= 1'b0;
        else if (wr_ctrl)
            self_q <= bus_wdata[SELF_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CNT:  bus_rdata = DATA_W'(cnt_q);
            OFF_LOAD: bus_rdata = DATA_W'(load_q);
            OFF_CTRL: begin
                bus_rdata[EN_BIT]   = running;
                bus_rdata[SELF_BIT] = self_q;
            end
            OFF_MASK: bus_rdata[PER_BIT] = mask_q;
            OFF_RAW:  bus_rdata[PER_BIT] = raw_q;
            OFF_MIS:  bus_rdata[PER_BIT] = raw_q & mask_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             ctrl_en,
    input  logic             self_q,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] load_q,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pit_state_t state_q, state_d;
    logic             start_req, stop_req, cnt_ld, cnt_dec;
    logic [CNT_W-1:0] start_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state and controls
    always_comb begin
        start_req = 1'b0;
        stop_req  = 1'b0;
        cnt_ld    = 1'b0;
        cnt_dec   = 1'b0;
        expire    = 1'b0;
        start_val = wr_load ? wr_val : load_q;
        state_d   = state_q;
        unique case (state_q)
            S_IDLE: begin
                start_req = (wr_ctrl && ctrl_en) || (wr_load && self_q);
                if (start_req)
                    state_d = (start_val == '0) ? S_STALL : S_RUN;
            end
            S_RUN: begin
                stop_req = wr_ctrl && !ctrl_en;
                if (stop_req)
                    state_d = S_IDLE;
                else if (tick) begin
                    if (cnt_q == ONE) begin
                        expire = 1'b1;
                        cnt_ld = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            S_STALL: begin
                stop_req = wr_ctrl && !ctrl_en;
                if (stop_req)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign running = (state_q != S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '0;
        else if (wr_load && state_q == S_IDLE)
            load_q <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_req)
            cnt_q <= start_val;
        else if (cnt_ld)
            cnt_q <= load_q;
        else if (cnt_dec)
            cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/pit_irq.sv
module pit_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic wr_mask,
    input  logic wr_clr,
    input  logic wbit,
    output logic raw_q,
    output logic mask_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b0;
        else if (wr_mask)
            mask_q <= wbit;
    end

    // a fresh expiry outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (expire)
            raw_q <= 1'b1;
        else if (wr_clr && wbit)
            raw_q <= 1'b0;
    end

    assign irq = raw_q & mask_q;
endmodule

// File: rtl/pit_top.sv
module pit_top
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic             wr_load, wr_ctrl, wr_mask, wr_clr, self_q;
    logic [CNT_W-1:0] cnt_q, load_q;
    logic             running, expire, raw_q, mask_q;

    pit_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .cnt_q(cnt_q), .load_q(load_q), .running(running),
        .raw_q(raw_q), .mask_q(mask_q),
        .wr_load(wr_load), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
        .wr_clr(wr_clr), .self_q(self_q), .bus_rdata(bus_rdata)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_load(wr_load), .wr_ctrl(wr_ctrl),
        .ctrl_en(bus_wdata[EN_BIT]), .self_q(self_q),
        .wr_val(bus_wdata[CNT_W-1:0]),
        .cnt_q(cnt_q), .load_q(load_q), .running(running), .expire(expire)
    );

    pit_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .wr_mask(wr_mask), .wr_clr(wr_clr), .wbit(bus_wdata[PER_BIT]),
        .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
    );
endmodule

// File: rtl/pit_chk.sv
module pit_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             wbit,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic             raw,
    input logic             irq
);
    logic any_wr, clr_hit;
    assign any_wr  = bus_sel && bus_wr;
    assign clr_hit = any_wr && (bus_addr == OFF_CLR) && wbit;

    // R3
    status_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(tick && running));

    // R4
    load_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(load));

    // R6
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !any_wr) |=> $stable(cnt));

    // R7
    zero_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == '0) |=> !$rose(raw));

    // R8
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_hit) |=> raw);

    // R9
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);
endmodule

bind pit_top pit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wbit(bus_wdata[1]), .running(running), .cnt(cnt_q), .load(load_q),
    .raw(raw_q), .irq(irq)
);

// File: tb/pit_top_test.sv
module pit_top_test;
    localparam logic [7:0] A_MASK = 8'h10, A_RAW = 8'h14, A_MIS = 8'h18,
                           A_CLR = 8'h1C, A_CNT = 8'h20, A_LOAD = 8'h24,
                           A_CTRL = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    pit_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares each read against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_sel && !bus_wr && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (bus_rdata !== it.exp || bus_addr !== it.addr) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic tick_with_clear();
        @(negedge clk);
        tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h2;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        #2;
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(A_CNT, 0, "R1 count");
        expect_rd(A_LOAD, 0, "R1 load");
        expect_rd(A_CTRL, 0, "R1 ctrl");
        expect_rd(A_MASK, 0, "R1 mask");
        expect_rd(A_RAW, 0, "R1 raw");
        expect_rd(A_MIS, 0, "R1 masked");
        chk_irq(1'b0, "R1 irq");

        // R5 load write while stopped does not start
        wr(A_LOAD, 5);
        expect_rd(A_LOAD, 5, "R5 load accepted");
        expect_rd(A_CTRL, 0, "R5 not started");
        ticks(2);
        expect_rd(A_CNT, 0, "R5 count idle");

        // R2 enable copies load
        wr(A_CTRL, 32'h2);
        expect_rd(A_CNT, 5, "R2 count loaded");
        expect_rd(A_CTRL, 2, "R2 ctrl enabled");

        // R3 countdown and reload
        ticks(3);
        expect_rd(A_CNT, 2, "R3 decrement");
        ticks(1);
        expect_rd(A_CNT, 1, "R3 at one");
        expect_rd(A_RAW, 0, "R3 no early status");
        ticks(1);
        expect_rd(A_CNT, 5, "R3 reload");
        expect_rd(A_RAW, 2, "R3 status set");

        // R4 load write while running ignored
        wr(A_LOAD, 9);
        expect_rd(A_LOAD, 5, "R4 load unchanged");
        ticks(4);
        expect_rd(A_CNT, 1, "R4 period kept");
        ticks(1);
        expect_rd(A_CNT, 5, "R4 reload to old value");

        // R9 mask and masked status
        expect_rd(A_MIS, 0, "R9 masked off");
        chk_irq(1'b0, "R9 irq masked");
        wr(A_MASK, 32'h2);
        expect_rd(A_MIS, 2, "R9 masked on");
        chk_irq(1'b1, "R9 irq on");
        wr(A_MASK, 32'hFFFF_FFFF);
        expect_rd(A_MASK, 2, "R9 mask only bit1");

        // R8 sticky and clear
        wr(A_CLR, 32'h0);
        expect_rd(A_RAW, 2, "R8 zero clear ignored");
        wr(A_CLR, 32'h2);
        expect_rd(A_RAW, 0, "R8 cleared");
        chk_irq(1'b0, "R8 irq after clear");
        ticks(4);
        expect_rd(A_CNT, 1, "R8 count before collide");
        tick_with_clear();
        expect_rd(A_RAW, 2, "R8 event beats clear");
        expect_rd(A_CNT, 5, "R8 reload on collide");

        // R6 stop holds count
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h2);
        ticks(10);
        expect_rd(A_CNT, 5, "R6 count held");
        expect_rd(A_RAW, 0, "R6 no status");
        expect_rd(A_CTRL, 0, "R6 ctrl stopped");

        // R5 stopped load write, then self-start
        wr(A_LOAD, 3);
        expect_rd(A_LOAD, 3, "R5 load when stopped");
        expect_rd(A_CNT, 5, "R5 count untouched");
        wr(A_CTRL, 32'h1);
        expect_rd(A_CTRL, 1, "R5 self bit only");
        wr(A_LOAD, 2);
        expect_rd(A_CTRL, 3, "R5 self started");
        expect_rd(A_CNT, 2, "R5 count from write");
        ticks(1);
        expect_rd(A_CNT, 1, "R5 counting");
        ticks(1);
        expect_rd(A_RAW, 2, "R5 expiry");
        expect_rd(A_CNT, 2, "R5 reload");

        // R7 zero period
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h2);
        wr(A_LOAD, 0);
        wr(A_CTRL, 32'h2);
        expect_rd(A_CTRL, 2, "R7 enabled");
        expect_rd(A_CNT, 0, "R7 count zero");
        ticks(5);
        expect_rd(A_CNT, 0, "R7 count stays zero");
        expect_rd(A_RAW, 0, "R7 no status");

        // R3 period of one
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 1);
        wr(A_CTRL, 32'h2);
        expect_rd(A_CNT, 1, "R3 load one");
        ticks(1);
        expect_rd(A_RAW, 2, "R3 one-tick expiry");
        expect_rd(A_CNT, 1, "R3 one reload");
        chk_irq(1'b1, "R9 irq follows masked");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        done = 1;
        report();
    end
endmodule